// File: doc/BRIEF.md
# DMA Interrupt Status Aggregator

This block gathers single-cycle event pulses from a network DMA engine and holds each one in a sticky status bit. Software clears a bit by writing 1 to its position. Every status bit has its own enable bit. The enabled status bits are split into two fixed groups. The first group covers routine completion and availability events and forms the normal summary. The second group covers error and stall conditions and forms the abnormal summary. Each summary has its own enable, and the enabled summaries are ORed with three level interrupts from neighbouring sub-blocks (statistics counters, power management and timestamp) to drive one registered interrupt line.

Because the line is a level, a burst of simultaneous events gives a single assertion. The line stays high until software has cleared every enabled pending bit. If software clears one bit while another enabled bit is still pending, the line stays asserted. A wakeup request from the power-management logic drives its own registered output and never touches the main line. Software uses a small register port to reach two registers: the status register (select 0) and the enable register (select 1).

Top module: `dma_irq_agg`

## Requirements
- R1: After reset, the status register, the enable register, `irq_o` and `wake_irq_o` all read 0.
- R2: A pulse on `evt_i[k]` sets status bit k in the next cycle, and the bit stays set until software clears it.
- R3: A write to the status register clears each event bit whose data bit is 1. Bits written with 0 keep their value.
- R4: If an event pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: Status and enable bit positions are: 0 transmit done, 1 transmit buffer unavailable, 2 early receive, 3 transmit stopped, 4 jabber timeout, 5 receive overflow, 6 receive done, 7 receive buffer unavailable, 8 transmit underflow, 9 receive stopped, 10 receive watchdog timeout, 11 early transmit, 12 fatal bus error. Bit 13 reads 0.
- R6: Status bit 14 (read-only) is the OR of bits 0, 1, 2 and 6, each ANDed with the enable bit at the same position. Enable bit 14 is the normal summary enable.
- R7: Status bit 15 (read-only) is the OR of bits 3, 4, 5, 7, 8, 9, 10, 11 and 12, each ANDed with its own enable bit. Enable bit 15 is the abnormal summary enable.
- R8: On each clock edge, `irq_o` takes the value (bit14 AND en14) OR (bit15 AND en15) OR any sub-block input, so it follows a status change by one cycle.
- R9: `cnt_irq_i`, `pm_irq_i` and `ts_irq_i` reach `irq_o` whatever the enable register holds.
- R10: After one of two enabled pending bits is cleared, `irq_o` stays asserted. It falls only when no enabled pending bit and no sub-block input remains.
- R11: `wake_irq_o` is `wake_evt_i` delayed by one clock. Wake activity does not affect `irq_o`, and status activity does not affect `wake_irq_o`.
- R12: Writes to status bits 13 to 15 have no effect. The enable register stores bits 0 to 12, 14 and 15, and its bit 13 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 13 | One-cycle event pulses, one per status bit position |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 status, 1 enable |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data of the selected register |
| cnt_irq_i | input | 1 | Counter sub-block interrupt level |
| pm_irq_i | input | 1 | Power-management interrupt level |
| ts_irq_i | input | 1 | Timestamp interrupt level |
| wake_evt_i | input | 1 | Wakeup request from power management |
| irq_o | output | 1 | Main interrupt line, registered |
| wake_irq_o | output | 1 | Wakeup interrupt line, registered |

## Verification
A status bit that is wrongly held or wrongly dropped shows up on the read port on the very next cycle. On `irq_o` it shows one cycle later, for as long as that bit is enabled. A summary that drew on the wrong group would make `irq_o` respond to an event class whose summary enable is off. This is caught once the bench runs with only one summary enabled. Crossed wake and main paths show up as a one-cycle glitch on the wrong output. The bench therefore compares both outputs and the read data against a behavioural model on every cycle, so any divergence is reported in the cycle it first appears.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_EVT = 13;

  localparam int B_TX_DONE  = 0;
  localparam int B_TX_NOBUF = 1;
  localparam int B_RX_EARLY = 2;
  localparam int B_TX_STOP  = 3;
  localparam int B_TX_JAB   = 4;
  localparam int B_RX_OVF   = 5;
  localparam int B_RX_DONE  = 6;
  localparam int B_RX_NOBUF = 7;
  localparam int B_TX_UNDER = 8;
  localparam int B_RX_STOP  = 9;
  localparam int B_RX_WDOG  = 10;
  localparam int B_TX_EARLY = 11;
  localparam int B_BUS_FAIL = 12;
  localparam int B_NSUM     = 14;
  localparam int B_ASUM     = 15;

  localparam logic [NUM_EVT-1:0] NORM_MASK =
      (NUM_EVT'(1) << B_TX_DONE)  | (NUM_EVT'(1) << B_TX_NOBUF) |
      (NUM_EVT'(1) << B_RX_EARLY) | (NUM_EVT'(1) << B_RX_DONE);
  localparam logic [NUM_EVT-1:0] ABN_MASK = ~NORM_MASK;

  typedef enum logic {
    SEL_STAT = 1'b0,
    SEL_EN   = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic [NUM_EVT-1:0] clr_i,
  output logic [NUM_EVT-1:0] stat_o
);
  logic [NUM_EVT-1:0] stat_q, stat_nxt;
  logic               stat_upd;

  always_comb begin
    stat_upd = (|evt_i) | (|clr_i);
    stat_nxt = (stat_q & ~clr_i) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)       stat_q <= '0;
    else if (stat_upd) stat_q <= stat_nxt;
  end

  assign stat_o = stat_q;

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    (|stat_q) |=> ((($past(stat_q) & ~$past(clr_i)) & ~stat_q) == '0)); // R2
  AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_ni)
    (|(clr_i & ~evt_i)) |=> ((stat_q & $past(clr_i & ~evt_i)) == '0)); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_ni)
    (|evt_i) |=> ((stat_q & $past(evt_i)) == $past(evt_i))); // R4
endmodule

// File: rtl/dma_irq_enable.sv
module dma_irq_enable
  import dma_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] en_o
);
  localparam logic [REG_W-1:0] WMASK =
      REG_W'({NUM_EVT{1'b1}}) | (REG_W'(1) << B_NSUM) | (REG_W'(1) << B_ASUM);

  logic [REG_W-1:0] en_q, en_nxt;

  always_comb en_nxt = wdata_i & WMASK;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)   en_q <= '0;
    else if (wr_i) en_q <= en_nxt;
  end

  assign en_o = en_q;

  AST_EN_STABLE: assert property (@(posedge clk) disable iff (!rst_ni)
    !wr_i |=> $stable(en_o)); // R12
endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary
  import dma_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] stat_i,
  input  logic [REG_W-1:0]   en_i,
  input  logic               cnt_irq_i,
  input  logic               pm_irq_i,
  input  logic               ts_irq_i,
  output logic               nsum_o,
  output logic               asum_o,
  output logic               irq_o
);
  logic [NUM_EVT-1:0] masked;
  logic               ext_any, irq_nxt, irq_q;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_mask
    assign masked[g] = stat_i[g] & en_i[g];
  end

  always_comb begin
    nsum_o  = |(masked & NORM_MASK);
    asum_o  = |(masked & ABN_MASK);
    ext_any = cnt_irq_i | pm_irq_i | ts_irq_i;
    irq_nxt = (nsum_o & en_i[B_NSUM]) | (asum_o & en_i[B_ASUM]) | ext_any;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_nxt;
  end

  assign irq_o = irq_q;

  AST_NSUM_SRC: assert property (@(posedge clk) disable iff (!rst_ni)
    nsum_o |-> (|(stat_i & NORM_MASK))); // R6
  AST_ASUM_SRC: assert property (@(posedge clk) disable iff (!rst_ni)
    asum_o |-> (|(stat_i & ABN_MASK))); // R7
  AST_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_ni)
    (cnt_irq_i || pm_irq_i || ts_irq_i) |=> irq_o); // R9
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_ni)
    (!cnt_irq_i && !pm_irq_i && !ts_irq_i && !nsum_o && !asum_o) |=> !irq_o); // R8
endmodule

// File: rtl/dma_irq_agg.sv
module dma_irq_agg
  import dma_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               reg_wr_i,
  input  logic               reg_sel_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               cnt_irq_i,
  input  logic               pm_irq_i,
  input  logic               ts_irq_i,
  input  logic               wake_evt_i,
  output logic               irq_o,
  output logic               wake_irq_o
);
  logic [1:0]         rst_sync_q;
  logic               rst_in;
  logic [NUM_EVT-1:0] stat, clr_vec;
  logic [REG_W-1:0]   en, rd_stat;
  logic               nsum, asum, wr_en_reg, wake_q;
  reg_sel_e           sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_in = rst_sync_q[1];

  always_comb begin
    sel       = reg_sel_e'(reg_sel_i);
    clr_vec   = (reg_wr_i && sel == SEL_STAT) ? reg_wdata_i[NUM_EVT-1:0] : '0;
    wr_en_reg = reg_wr_i && sel == SEL_EN;
  end

  dma_irq_status u_status (
    .clk    (clk),
    .rst_ni (rst_in),
    .evt_i  (evt_i),
    .clr_i  (clr_vec),
    .stat_o (stat)
  );

  dma_irq_enable u_enable (
    .clk     (clk),
    .rst_ni  (rst_in),
    .wr_i    (wr_en_reg),
    .wdata_i (reg_wdata_i),
    .en_o    (en)
  );

  dma_irq_summary u_summary (
    .clk       (clk),
    .rst_ni    (rst_in),
    .stat_i    (stat),
    .en_i      (en),
    .cnt_irq_i (cnt_irq_i),
    .pm_irq_i  (pm_irq_i),
    .ts_irq_i  (ts_irq_i),
    .nsum_o    (nsum),
    .asum_o    (asum),
    .irq_o     (irq_o)
  );

  always_comb begin
    rd_stat                = '0;
    rd_stat[NUM_EVT-1:0]   = stat;
    rd_stat[B_NSUM]        = nsum;
    rd_stat[B_ASUM]        = asum;
    reg_rdata_o            = (sel == SEL_EN) ? en : rd_stat;
  end

  always_ff @(posedge clk or negedge rst_in) begin
    if (!rst_in) wake_q <= 1'b0;
    else         wake_q <= wake_evt_i;
  end
  assign wake_irq_o = wake_q;

  AST_WAKE_SRC: assert property (@(posedge clk) disable iff (!rst_in)
    $rose(wake_irq_o) |-> $past(wake_evt_i)); // R11
  AST_WAKE_DROP: assert property (@(posedge clk) disable iff (!rst_in)
    $fell(wake_irq_o) |-> !$past(wake_evt_i)); // R11
endmodule

// File: tb/dma_irq_agg_tb.sv
module dma_irq_agg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] evt = '0;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        cnt_irq = 1'b0, pm_irq = 1'b0, ts_irq = 1'b0, wake_evt = 1'b0;
  logic        irq, wake_irq;

  int    n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  always #4 clk = ~clk;

  dma_irq_agg dut_i (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .cnt_irq_i(cnt_irq),
    .pm_irq_i(pm_irq), .ts_irq_i(ts_irq), .wake_evt_i(wake_evt),
    .irq_o(irq), .wake_irq_o(wake_irq)
  );

  // Behavioural reference model
  bit   m_stat [13];
  bit   m_en   [16];
  bit   m_irq, m_wake;
  int   since_rel = 0;
  int   norm_idx[$] = '{0, 1, 2, 6};
  int   abn_idx[$]  = '{3, 4, 5, 7, 8, 9, 10, 11, 12};

  function automatic bit m_nsum();
    bit r = 0;
    foreach (norm_idx[i]) r |= m_stat[norm_idx[i]] & m_en[norm_idx[i]];
    return r;
  endfunction

  function automatic bit m_asum();
    bit r = 0;
    foreach (abn_idx[i]) r |= m_stat[abn_idx[i]] & m_en[abn_idx[i]];
    return r;
  endfunction

  function automatic logic [15:0] m_rdata();
    logic [15:0] r = '0;
    if (reg_sel) begin
      for (int i = 0; i < 16; i++) r[i] = m_en[i];
    end else begin
      for (int i = 0; i < 13; i++) r[i] = m_stat[i];
      r[14] = m_nsum();
      r[15] = m_asum();
    end
    return r;
  endfunction

  task automatic m_zero();
    foreach (m_stat[i]) m_stat[i] = 0;
    foreach (m_en[i]) m_en[i] = 0;
    m_irq = 0;
    m_wake = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rel = 0;
      m_zero();
    end else if (since_rel < 2) begin
      since_rel++;
      m_zero();
    end else begin
      m_irq  = (m_nsum() & m_en[14]) | (m_asum() & m_en[15]) | cnt_irq | pm_irq | ts_irq;
      m_wake = wake_evt;
      for (int i = 0; i < 13; i++) begin
        if (reg_wr && !reg_sel && reg_wdata[i]) m_stat[i] = 0;
        if (evt[i]) m_stat[i] = 1;
      end
      if (reg_wr && reg_sel)
        for (int i = 0; i < 16; i++) m_en[i] = (i == 13) ? 1'b0 : reg_wdata[i];
    end
  end

  task automatic check(string req, string what, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(cur_req, "irq_o", {15'b0, irq}, {15'b0, m_irq});
      check(cur_req, "wake_irq_o", {15'b0, wake_irq}, {15'b0, m_wake});
      check(cur_req, "reg_rdata_o", reg_rdata, m_rdata());
    end
  end

  task automatic step(input logic [12:0] e, input logic wr, input logic sel, input logic [15:0] wd);
    @(negedge clk); #1;
    evt = e; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    @(posedge clk); #1;
    evt = '0; reg_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);
    cur_req = "R1";
    check("R1", "status after reset", reg_rdata, 16'h0000);
    step('0, 0, 1, 0); idle(1);
    check("R1", "enable after reset", reg_rdata, 16'h0000);
    check("R1", "irq after reset", {15'b0, irq}, 16'h0000);

    cur_req = "R5";
    step(13'h0040, 0, 0, 0); idle(1);
    check("R5", "receive done at bit 6", reg_rdata, 16'h0040);
    cur_req = "R3";
    step('0, 1, 0, 16'h0000); idle(1);
    check("R3", "write 0 keeps bit", reg_rdata, 16'h0040);
    step('0, 1, 0, 16'h0040); idle(1);
    check("R3", "write 1 clears bit", reg_rdata, 16'h0000);

    cur_req = "R12";
    step('0, 1, 1, 16'hFFFF); idle(1);
    check("R12", "enable writable bits", reg_rdata, 16'hDFFF);

    cur_req = "R8";
    step(13'h00C0, 0, 0, 0); idle(2);
    check("R8", "irq on combined events", {15'b0, irq}, 16'h0001);
    check("R6", "status with both summaries", reg_rdata, 16'hC0C0);
    cur_req = "R10";
    step('0, 1, 0, 16'h0040); idle(2);
    check("R10", "irq held by pending bit 7", {15'b0, irq}, 16'h0001);
    step('0, 1, 0, 16'h0080); idle(2);
    check("R10", "irq drops when all clear", {15'b0, irq}, 16'h0000);

    cur_req = "R4";
    step(13'h0008, 1, 0, 16'h0008); idle(1);
    check("R4", "set beats clear", reg_rdata, 16'h8008);
    cur_req = "R12";
    step('0, 1, 0, 16'hE000); idle(1);
    check("R12", "summary bits unaffected", reg_rdata, 16'h8008);
    step('0, 1, 0, 16'h1FFF); idle(2);

    cur_req = "R7";
    step('0, 1, 1, 16'h4FFF); step('0, 0, 0, 0);
    step(13'h0010, 0, 0, 0); idle(2);
    check("R7", "abnormal masked by summary enable", {15'b0, irq}, 16'h0000);
    cur_req = "R6";
    step(13'h0001, 0, 0, 0); idle(2);
    check("R6", "normal summary raises irq", {15'b0, irq}, 16'h0001);
    step('0, 1, 0, 16'h1FFF);

    cur_req = "R9";
    step('0, 1, 1, 16'h0000);
    @(negedge clk); #1 cnt_irq = 1; idle(2);
    check("R9", "counter input unmasked", {15'b0, irq}, 16'h0001);
    #1 cnt_irq = 0; pm_irq = 1; idle(2); #1 pm_irq = 0; ts_irq = 1; idle(2); #1 ts_irq = 0;
    idle(2);

    cur_req = "R11";
    #1 wake_evt = 1; idle(2);
    check("R11", "wake output", {15'b0, wake_irq}, 16'h0001);
    check("R11", "main line untouched", {15'b0, irq}, 16'h0000);
    #1 wake_evt = 0; idle(2);

    cur_req = "R2";
    for (int k = 0; k < 600; k++) begin
      logic [12:0] e;
      logic [15:0] w;
      e = 13'($urandom) & 13'($urandom) & 13'($urandom);
      w = 16'($urandom);
      @(negedge clk); #1;
      cnt_irq  = ($urandom % 16) == 0;
      wake_evt = ($urandom % 8) == 0;
      step(e, ($urandom % 3) == 0, ($urandom % 4) == 0, w);
    end
    cnt_irq = 0; wake_evt = 0;
    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule